// File: doc/BRIEF.md
# Fractional-Rate Realtime Counter

This block keeps a free-running 64-bit count that advances at one fixed nominal rate (6.144 MHz in the intended use) whatever the frequency of the clock it runs on. On every clock it adds a programmable numerator to a fractional accumulator. Whenever the sum reaches the programmable denominator, it takes the denominator off again and the count steps by one. Picking the numerator/denominator pair to match the input clock gives the same output rate from many different sources. Some examples: 4/25 for 38.4 MHz, 8/25 for 19.2 MHz, 64/125 for 12 MHz, 768/1625 for 13 MHz, 384/1625 for 26 MHz and 256/1125 for 27 MHz.

Software sets the ratio through a small register window. The ratio numerator sits at offset 0x10 and the denominator at 0x14, each in the low 12 bits of its word. The count goes straight to local timer peripherals on a wide output port. Software reads it as two halves, and reading the low half freezes a copy of the high half, so the two reads always form one coherent value.

Top module: `rtc_top`

## Requirements
- R1: While reset is asserted the count is zero, the numerator register reads 0x0000_0004, the denominator register reads 0x0000_0019, and the high-half snapshot at offset 0x04 reads zero.
- R2: With 0 < numerator <= denominator, the count grows by exactly floor(N*numerator/denominator) over N clocks that follow a clear of the accumulator. It never moves by more than one per clock.
- R3: Only bits [11:0] of the word at 0x10 (numerator) and the word at 0x14 (denominator) set the ratio. Bits [31:12] of each word are stored as written, read back unchanged, and do not affect the rate.
- R4: The fractional accumulator always stays below a nonzero denominator, so the rate stays exact over any window length.
- R5: A write to 0x10 or 0x14 clears the accumulator, and the count does not step in that clock.
- R6: While the denominator field is zero, the count holds its value.
- R7: When the numerator field is larger than a nonzero denominator field, the count steps by exactly one on every clock.
- R8: A read at offset 0x00 returns the low half of the count and, on the same clock edge, captures the high half. A read at 0x04 returns the captured high half, not the live one.
- R9: Writes to 0x00, 0x04 or any unmapped offset change neither the count, the accumulator nor the ratio registers. Reads of unmapped offsets return zero.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe, one clock per write |
| reg_rd | input | 1 | Register read strobe; a read at 0x00 captures the high half |
| reg_addr | input | 8 | Byte offset within the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data; valid in the same clock as reg_rd, zero when idle |
| count_o | output | CNT_W | Live count for local timer peripherals |

## Verification
The bench measures the count gain over windows that start right after a ratio write. It uses all six listed ratio pairs and random ratios, so an accumulator that drifts, keeps a stale remainder or compares with > instead of >= ends up with a wrong total. It forces a carry from the low half into the high half, then reads the high half after the carry. A design that returns the live high half instead of the captured one is exposed there. It also writes a zero denominator, a numerator above the denominator, upper-bit patterns in the ratio words and stray writes to the count and unmapped offsets. This catches a counter that runs on with a zero divisor, one that stalls when the ratio exceeds one, reserved bits that change the rate, and writes that wrongly clear the accumulator.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;

  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_NUM    = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_DEN    = 8'h14;
endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int FRAC_W  = 12,
  parameter int HALF_W  = 32,
  parameter int RST_NUM = 4,
  parameter int RST_DEN = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [HALF_W-1:0] cnt_lo,
  input  logic [HALF_W-1:0] snap_hi,
  output logic [BUS_W-1:0]  rdata,
  output logic [FRAC_W-1:0] num_f,
  output logic [FRAC_W-1:0] den_f,
  output logic              ratio_wr,
  output logic              snap_en
);
  logic [BUS_W-1:0] num_q, num_d, den_q, den_d;
  logic             num_we, den_we;
  logic [BUS_W-1:0] mux;

  // address decode and clock enables
  always_comb begin
    num_we   = wr_en && (addr == OFF_NUM);
    den_we   = wr_en && (addr == OFF_DEN);
    ratio_wr = num_we || den_we;
    snap_en  = rd_en && (addr == OFF_CNT_LO);
    num_d    = num_we ? wdata : num_q;
    den_d    = den_we ? wdata : den_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= BUS_W'(RST_NUM);
      den_q <= BUS_W'(RST_DEN);
    end else begin
      if (num_we) num_q <= num_d;
      if (den_we) den_q <= den_d;
    end
  end

  assign num_f = num_q[FRAC_W-1:0];
  assign den_f = den_q[FRAC_W-1:0];

  // readback
  always_comb begin
    case (addr)
      OFF_CNT_LO: mux = BUS_W'(cnt_lo);
      OFF_CNT_HI: mux = BUS_W'(snap_hi);
      OFF_NUM:    mux = num_q;
      OFF_DEN:    mux = den_q;
      default:    mux = '0;
    endcase
    rdata = rd_en ? mux : '0;
  end

  AST_STRAY_WR_KEEPS_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != OFF_NUM && addr != OFF_DEN) |=> ($stable(num_q) && $stable(den_q))); // R9
endmodule

// File: rtl/rtc_frac_acc.sv
module rtc_frac_acc #(
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAC_W-1:0] num,
  input  logic [FRAC_W-1:0] den,
  input  logic              clr,
  output logic              step_o
);
  localparam int ACC_W = FRAC_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W-1:0] sum, den_x;
  logic             acc_en;

  always_comb begin
    den_x  = {1'b0, den};
    sum    = acc_q + {1'b0, num};
    acc_d  = acc_q;
    acc_en = 1'b1;
    step_o = 1'b0;
    if (clr) begin
      acc_d = '0;                       // ratio change discards remainder
    end else if (den == '0) begin
      acc_en = 1'b0;                    // zero divisor: frozen
    end else if (num > den) begin
      acc_d  = '0;                      // rate saturates at one per clock
      step_o = 1'b1;
    end else if (sum >= den_x) begin
      acc_d  = sum - den_x;
      step_o = 1'b1;
    end else begin
      acc_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    (den != '0) |-> (acc_q < {1'b0, den})); // R4
  AST_WR_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0)); // R5
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W = 64,
  parameter int SEG_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                snap_en,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [CNT_W/2-1:0]  snap_hi
);
  localparam int HALF_W = CNT_W / 2;
  localparam int NSEG   = CNT_W / SEG_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [NSEG-1:0]   seg_en;
  logic [HALF_W-1:0] snap_q;

  // segmented carry chain: each slice steps only when all below are full
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [SEG_W-1:0] seg_q, seg_d;
    if (g == 0) begin : g_base
      assign seg_en[g] = step;
    end else begin : g_carry
      assign seg_en[g] = seg_en[g-1] && (&g_seg[g-1].seg_q);
    end
    always_comb seg_d = seg_q + SEG_W'(1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         seg_q <= '0;
      else if (seg_en[g]) seg_q <= seg_d;
    end
    assign cnt_o[g*SEG_W +: SEG_W] = seg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_en) snap_q <= cnt_o[CNT_W-1:HALF_W];
  end
  assign snap_hi = snap_q;

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + ONE)); // R2
  AST_SNAP_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
    snap_en |=> (snap_hi == $past(cnt_o[CNT_W-1:HALF_W]))); // R8
endmodule

// File: rtl/rtc_top.sv
module rtc_top
  import rtc_pkg::*;
#(
  parameter int FRAC_W  = 12,
  parameter int CNT_W   = 64,
  parameter int SEG_W   = 16,
  parameter int RST_NUM = 4,
  parameter int RST_DEN = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic [CNT_W-1:0]  count_o
);
  localparam int HALF_W = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic              rst_meta, rst_sync_n;
  logic [FRAC_W-1:0] num_f, den_f;
  logic              ratio_wr, snap_en, step;
  logic [HALF_W-1:0] snap_hi;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  rtc_regs #(
    .FRAC_W (FRAC_W), .HALF_W (HALF_W), .RST_NUM(RST_NUM), .RST_DEN(RST_DEN)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_wr),
    .rd_en   (reg_rd),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .cnt_lo  (count_o[HALF_W-1:0]),
    .snap_hi (snap_hi),
    .rdata   (reg_rdata),
    .num_f   (num_f),
    .den_f   (den_f),
    .ratio_wr(ratio_wr),
    .snap_en (snap_en)
  );

  rtc_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .num   (num_f),
    .den   (den_f),
    .clr   (ratio_wr),
    .step_o(step)
  );

  rtc_counter #(.CNT_W(CNT_W), .SEG_W(SEG_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .step   (step),
    .snap_en(snap_en),
    .cnt_o  (count_o),
    .snap_hi(snap_hi)
  );

  AST_ZERO_DEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (den_f == '0) |=> $stable(count_o)); // R6
  AST_FAST_RATIO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (den_f != '0 && num_f > den_f && !ratio_wr) |=> (count_o == $past(count_o) + ONE)); // R7
  AST_WR_NO_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ratio_wr |=> $stable(count_o)); // R5
endmodule

// File: tb/sim_rtc_top.sv
module sim_rtc_top;
  // narrower counter so the bench can reach the carry into the upper half
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr, reg_rd;
  logic [7:0]    reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [CW-1:0] count_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  rtc_top #(.CNT_W(CW), .SEG_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .count_o(count_o)
  );

  function automatic longint unsigned exp_steps(int n, int num, int den);
    if (den == 0) return 0;
    if (num >= den) return longint'(n);
    return (longint'(n) * longint'(num)) / longint'(den);
  endfunction

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic set_ratio(int num, int den);
    wr(8'h10, 32'(num));
    wr(8'h14, 32'(den));
  endtask

  task automatic window(string req, int num, int den, int n);
    longint unsigned c0;
    set_ratio(num, den);
    c0 = count_o;
    tick(n);
    check(req, count_o, c0 + exp_steps(n, num, den));
  endtask

  initial begin
    for (int cyc = 0; cyc < 190000; cyc++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    longint unsigned c0, hi_exp;
    void'($urandom(32'd2024));
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    tick(2);
    // R1 reset values
    check("R1 count", count_o, 0);
    rd(8'h10, v); check("R1 num", v, 32'h4);
    rd(8'h14, v); check("R1 den", v, 32'h19);
    rd(8'h04, v); check("R1 snap", v, 0);
    rst_n = 1'b1;
    tick(4);

    // R2 listed ratios over long windows
    window("R2 4/25",      4,   25, 1000);
    window("R2 8/25",      8,   25, 1000);
    window("R2 64/125",   64,  125, 1000);
    window("R2 768/1625", 768, 1625, 3250);
    window("R2 384/1625", 384, 1625, 3251);
    window("R4 256/1125", 256, 1125, 2250);

    // R2/R4 random ratios and window lengths
    for (int i = 0; i < 40; i++) begin
      int den, num, n;
      den = 1 + int'($urandom % 4095);
      num = 1 + int'($urandom % den);
      n   = 20 + int'($urandom % 300);
      window("R2 random", num, den, n);
    end

    // R3 upper bits stored, ignored for rate
    set_ratio(0, 25);
    wr(8'h10, 32'hABCDE008);
    wr(8'h14, 32'hFFFFF019);
    rd(8'h10, v); check("R3 num readback", v, 32'hABCDE008);
    rd(8'h14, v); check("R3 den readback", v, 32'hFFFFF019);
    c0 = count_o;
    tick(500);
    check("R3 rate 8/25", count_o, c0 + exp_steps(500, 8, 25));

    // R5 ratio write holds count that cycle
    set_ratio(1, 1);
    tick(3);
    c0 = count_o;
    wr(8'h10, 32'h1);
    check("R5 no step on write", count_o, c0);
    tick(1);
    check("R5 resumes", count_o, c0 + 1);

    // R6 zero denominator
    set_ratio(7, 0);
    c0 = count_o;
    tick(100);
    check("R6 hold", count_o, c0);

    // R7 numerator above denominator
    window("R7 100/7", 100, 7, 50);
    window("R7 4095/1", 4095, 1, 33);

    // R9 stray writes, unmapped reads
    set_ratio(4, 25);
    c0 = count_o;
    tick(30);
    wr(8'h00, 32'h0);
    wr(8'h18, 32'h5);
    wr(8'h04, 32'hFFFF);
    tick(50);
    check("R9 count unaffected", count_o, c0 + exp_steps(83, 4, 25));
    rd(8'h18, v); check("R9 unmapped read", v, 0);
    rd(8'h10, v); check("R9 num kept", v, 32'h4);
    rd(8'h14, v); check("R9 den kept", v, 32'h19);

    // R8 coherent halves across the carry
    set_ratio(1, 1);
    while (count_o < 32'h0000FFF0) tick(1);
    reg_rd = 1'b1; reg_addr = 8'h00;
    #1 v = reg_rdata;
    hi_exp = count_o[31:16];
    check("R8 low half", v, {16'h0, count_o[15:0]});
    @(negedge clk);
    reg_rd = 1'b0;
    tick(40);
    check("R8 carry reached", count_o[31:16], 1);
    rd(8'h04, v2); check("R8 captured high", v2, hi_exp);
    rd(8'h00, v);
    rd(8'h04, v2); check("R8 recaptured high", v2, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule